// File: doc/BRIEF.md
# Single-Slope Converter Sequencer with Result Stability Filter

This block is the digital half of an 8-bit ramp-compare analog-to-digital converter. A start pulse clears a ramp-step counter. The counter then climbs one step per clock and is driven out to the analog ramp. The block watches a 1-bit comparator that reports when the ramp has reached the selected input. The step at which the comparator first trips becomes the conversion code. A code of 00h means the input is at ground and FFh means it is at the reference. If the comparator never trips, the code stops at FFh.

Each code then passes through a stability filter before it is published. With the filter enabled, the published value moves only after four back-to-back conversions agree in their six most significant bits. With the filter bypassed, every conversion is published. The upper six bits of the published value are exported as a row index for downstream look-up tables.

A channel bit steers the analog input mux. The value 0 selects the on-chip temperature sensor and 1 selects the external sense input. Changing the channel discards any agreement history, so results from the two channels are never combined.

Top module: `ramp_adc`

## Requirements
- R1: A start pulse seen while idle resets the ramp step to 0, and the step then rises by one each clock. A start pulse seen during a conversion is ignored, and the conversion timing does not change.
- R2: The code is the ramp step at the first clock on which the comparator is high. For a trip at step v, `conv_done` is high in the (v+1)th cycle after the cycle in which `conv_start` was high, and `conv_code` then equals v.
- R3: If the comparator never trips, the conversion ends at step FFh with code FFh, 256 cycles after the start cycle.
- R4: `conv_done` is a single-cycle pulse, given once for each completed conversion.
- R5: With `filt_off`=0, `result` loads the full 8-bit code of the fourth consecutive conversion whose bits [7:2] match. The match count then restarts, so four further matches are needed for the next load.
- R6: With `filt_off`=0, a conversion whose bits [7:2] differ from those of the previous conversion restarts the match count at one.
- R7: With `filt_off`=1, `result` loads every completed code, and the match count is cleared.
- R8: `sense_sel` follows `chan_sel` one cycle later (0 = on-chip sensor, 1 = external input). Any change of `chan_sel` clears the match count.
- R9: `row_idx` equals `result[7:2]`. `result_upd` pulses, together with `conv_done`, on each load of `result`, and `result` holds its value in every other cycle.
- R10: After reset, `result`, `row_idx`, `ramp_code`, `conv_code`, `conv_done`, `result_upd` and `sense_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion start / ramp reset request |
| cmp_trip | input | 1 | Comparator: ramp at or above selected input |
| filt_off | input | 1 | 1 bypasses the stability filter |
| chan_sel | input | 1 | Input channel: 0 sensor, 1 external |
| ramp_code | output | 8 | Ramp step driven to the ramp generator |
| sense_sel | output | 1 | Registered analog mux select |
| conv_done | output | 1 | One-cycle pulse per finished conversion |
| conv_code | output | 8 | Code of the latest conversion |
| result | output | 8 | Published (filtered) value |
| row_idx | output | 6 | Look-up table row index, `result[7:2]` |
| result_upd | output | 1 | Pulse when `result` is loaded |

## Verification
A conversion that trips at step v reports its code and its done pulse v+1 cycles after the start cycle. The published value and its update pulse become visible on that same cycle. The channel mux select follows one cycle after its input. The bench stamps the cycle in which each start is taken and queues the expected code, latency and published value. The monitor samples on the falling edge. It compares each done pulse against the queued latency and values, and it flags any update pulse that has no matching done pulse.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
    localparam int ADC_W = 8;
    localparam int ROW_W = 6;
    localparam int AGREE_N = 4;

    typedef enum logic {PH_IDLE = 1'b0, PH_RAMP = 1'b1} phase_t;
endpackage

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
    import ramp_adc_pkg::*;
#(
    parameter int W = ADC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         trip_i,
    output logic [W-1:0] ramp_o,
    output logic         cap_vld_o,
    output logic [W-1:0] cap_code_o,
    output logic         done_o,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] STEP_MAX = {W{1'b1}};

    typedef struct packed {
        phase_t       ph;
        logic [W-1:0] step;
        logic         done;
        logic [W-1:0] code;
    } seq_t;

    seq_t s_d, s_q;
    logic cap_d;

    always_comb begin
        s_d = s_q;
        s_d.done = 1'b0;
        cap_d = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph = PH_RAMP;
                    s_d.step = '0;
                end
            end
            default: begin
                if (trip_i || s_q.step == STEP_MAX) begin
                    cap_d = 1'b1;
                    s_d.code = s_q.step;
                    s_d.done = 1'b1;
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, step: '0, done: 1'b0, code: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ramp_o = s_q.step;
    assign cap_vld_o = cap_d;
    assign cap_code_o = s_q.step;
    assign done_o = s_q.done;
    assign code_o = s_q.code;

    // R1
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RAMP && !trip_i && s_q.step != STEP_MAX)
        |=> (ramp_o == $past(ramp_o) + 1'b1));

    // R2
    trip_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RAMP && trip_i) |=> (done_o && code_o == $past(ramp_o)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/ramp_adc_filter.sv
module ramp_adc_filter
    import ramp_adc_pkg::*;
#(
    parameter int W = ADC_W,
    parameter int RW = ROW_W,
    parameter int MATCH_N = AGREE_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_vld_i,
    input  logic [W-1:0]  cap_code_i,
    input  logic          bypass_i,
    input  logic          chan_i,
    output logic          chan_o,
    output logic [W-1:0]  res_o,
    output logic [RW-1:0] row_o,
    output logic          upd_o
);
    localparam int CW = $clog2(MATCH_N + 1);

    typedef struct packed {
        logic          chan;
        logic [CW-1:0] cnt;
        logic [RW-1:0] prev;
        logic          valid;
        logic [W-1:0]  res;
        logic          upd;
    } flt_t;

    flt_t f_d, f_q;
    logic [RW-1:0] hi_d;
    logic [CW-1:0] next_cnt_d;

    always_comb begin
        f_d = f_q;
        f_d.upd = 1'b0;
        f_d.chan = chan_i;
        hi_d = cap_code_i[W-1 -: RW];
        next_cnt_d = (f_q.valid && hi_d == f_q.prev) ? f_q.cnt + 1'b1 : CW'(1);
        if (chan_i != f_q.chan) begin
            f_d.cnt = '0;
            f_d.valid = 1'b0;
        end else if (cap_vld_i) begin
            if (bypass_i) begin
                f_d.res = cap_code_i;
                f_d.upd = 1'b1;
                f_d.cnt = '0;
                f_d.valid = 1'b0;
            end else begin
                f_d.prev = hi_d;
                f_d.valid = 1'b1;
                if (next_cnt_d == CW'(MATCH_N)) begin
                    f_d.res = cap_code_i;
                    f_d.upd = 1'b1;
                    f_d.cnt = '0;
                end else begin
                    f_d.cnt = next_cnt_d;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{chan: 1'b0, cnt: '0, prev: '0, valid: 1'b0, res: '0, upd: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign chan_o = f_q.chan;
    assign res_o = f_q.res;
    assign row_o = f_q.res[W-1 -: RW];
    assign upd_o = f_q.upd;

    // R5
    agree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt < CW'(MATCH_N));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(res_o));

    // R8
    chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_i != chan_o) |=> (f_q.cnt == '0 && !upd_o));
endmodule

// File: rtl/ramp_adc.sv
module ramp_adc
    import ramp_adc_pkg::*;
#(
    parameter int W = ADC_W,
    parameter int RW = ROW_W,
    parameter int MATCH_N = AGREE_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_start,
    input  logic          cmp_trip,
    input  logic          filt_off,
    input  logic          chan_sel,
    output logic [W-1:0]  ramp_code,
    output logic          sense_sel,
    output logic          conv_done,
    output logic [W-1:0]  conv_code,
    output logic [W-1:0]  result,
    output logic [RW-1:0] row_idx,
    output logic          result_upd
);
    logic         cap_vld;
    logic [W-1:0] cap_code;

    ramp_adc_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(conv_start), .trip_i(cmp_trip),
        .ramp_o(ramp_code), .cap_vld_o(cap_vld), .cap_code_o(cap_code),
        .done_o(conv_done), .code_o(conv_code)
    );

    ramp_adc_filter #(.W(W), .RW(RW), .MATCH_N(MATCH_N)) u_flt (
        .clk(clk), .rst_n(rst_n), .cap_vld_i(cap_vld), .cap_code_i(cap_code),
        .bypass_i(filt_off), .chan_i(chan_sel), .chan_o(sense_sel),
        .res_o(result), .row_o(row_idx), .upd_o(result_upd)
    );

    // R9
    upd_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_upd |-> conv_done);
endmodule

// File: tb/test_ramp_adc.sv
module test_ramp_adc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0;
    logic filt_off = 1'b0;
    logic chan_sel = 1'b0;
    logic cmp_trip;
    logic [7:0] ramp_code, conv_code, result;
    logic [5:0] row_idx;
    logic sense_sel, conv_done, result_upd;
    logic [8:0] vin_sens = 9'd0;
    logic [8:0] vin_ext = 9'd0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        logic [7:0] code;
        int         lat;
        logic       upd;
        logic [7:0] res;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int start_q[$];

    logic [2:0] m_cnt = '0;
    logic [5:0] m_prev = '0;
    logic m_valid = 1'b0;
    logic [7:0] m_res = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign cmp_trip = ({1'b0, ramp_code} >= (sense_sel ? vin_ext : vin_sens));

    ramp_adc i_ramp_adc (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_trip(cmp_trip),
        .filt_off(filt_off), .chan_sel(chan_sel), .ramp_code(ramp_code),
        .sense_sel(sense_sel), .conv_done(conv_done), .conv_code(conv_code),
        .result(result), .row_idx(row_idx), .result_upd(result_upd)
    );

    task automatic check(input string tag, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic convert(input logic [8:0] vin, input string tag, input bit extra_start);
        exp_t e;
        logic [7:0] code;
        logic [5:0] hi;
        logic [2:0] nc;
        code = (vin > 9'd255) ? 8'hFF : vin[7:0];
        hi = code[7:2];
        e.upd = 1'b0;
        if (filt_off) begin
            m_res = code;
            e.upd = 1'b1;
            m_cnt = 0;
            m_valid = 1'b0;
        end else begin
            nc = (m_valid && hi == m_prev) ? m_cnt + 3'd1 : 3'd1;
            m_prev = hi;
            m_valid = 1'b1;
            if (nc == 3'd4) begin
                m_res = code;
                e.upd = 1'b1;
                m_cnt = 0;
            end else begin
                m_cnt = nc;
            end
        end
        if (chan_sel) vin_ext = vin; else vin_sens = vin;
        e.code = code;
        e.lat = int'(code) + 1;
        e.res = m_res;
        e.tag = tag;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        start_q.push_back(cyc);
        exp_q.push_back(e);
        if (extra_start) begin
            repeat (4) @(negedge clk);
            conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_chan(input logic c);
        chan_sel = c;
        m_cnt = 0;
        m_valid = 1'b0;
        @(negedge clk);
        check("R8 sense_sel follows chan_sel", int'(sense_sel), int'(c));
        @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        exp_t e;
        int st;
        forever begin
            @(negedge clk);
            if (rst_n && conv_done) begin
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R4 unexpected conv_done actual=1 expected=0");
                end else begin
                    e = exp_q.pop_front();
                    st = start_q.pop_front();
                    check({"R2 code ", e.tag}, int'(conv_code), int'(e.code));
                    check({"R2 latency ", e.tag}, cyc - st, e.lat);
                    check({"R9 result_upd ", e.tag}, int'(result_upd), int'(e.upd));
                    check({"R5 result ", e.tag}, int'(result), int'(e.res));
                    check({"R9 row_idx ", e.tag}, int'(row_idx), int'(e.res[7:2]));
                end
            end else if (rst_n && result_upd) begin
                tests++; fails++;
                $display("FAIL R9 result_upd without done actual=1 expected=0");
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 result", int'(result), 0);
        check("R10 row_idx", int'(row_idx), 0);
        check("R10 ramp_code", int'(ramp_code), 0);
        check("R10 conv_done", int'(conv_done), 0);
        check("R10 result_upd", int'(result_upd), 0);
        check("R10 sense_sel", int'(sense_sel), 0);
        check("R10 conv_code", int'(conv_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 four matches then publish; restart needs four more
        convert(9'd40, "R5 a1", 0);
        convert(9'd40, "R5 a2", 0);
        convert(9'd40, "R5 a3", 0);
        convert(9'd40, "R5 a4", 0);
        convert(9'd41, "R5 b1", 0);
        convert(9'd42, "R5 b2", 0);
        convert(9'd43, "R5 b3", 0);
        convert(9'd41, "R5 b4 full code", 0);
        check("R5 published full code", int'(result), 41);

        // R6 mismatch restarts at one
        convert(9'd100, "R6 c1", 0);
        convert(9'd100, "R6 c2", 0);
        convert(9'd100, "R6 c3", 0);
        convert(9'd200, "R6 mismatch", 0);
        convert(9'd201, "R6 d2", 0);
        convert(9'd202, "R6 d3", 0);
        check("R6 held before fourth", int'(result), 41);
        convert(9'd203, "R6 d4", 0);

        // R2/R3 boundary codes
        convert(9'd0, "R2 zero", 0);
        convert(9'd256, "R3 saturate", 0);
        convert(9'd255, "R3 top", 0);

        // R1 start during conversion ignored
        convert(9'd60, "R1 busy start", 1);

        // R8 channel change clears agreement
        set_chan(1'b0);
        convert(9'd80, "R8 s1", 0);
        convert(9'd80, "R8 s2", 0);
        convert(9'd80, "R8 s3", 0);
        set_chan(1'b1);
        convert(9'd80, "R8 e1", 0);
        convert(9'd80, "R8 e2", 0);
        convert(9'd80, "R8 e3", 0);
        convert(9'd82, "R8 e4", 0);

        // R7 bypass publishes every code and clears agreement
        convert(9'd10, "R7 pre1", 0);
        convert(9'd10, "R7 pre2", 0);
        filt_off = 1'b1;
        convert(9'd10, "R7 p1", 0);
        convert(9'd150, "R7 p2", 0);
        convert(9'd7, "R7 p3", 0);
        filt_off = 1'b0;
        convert(9'd7, "R7 after1", 0);
        convert(9'd7, "R7 after2", 0);
        convert(9'd7, "R7 after3", 0);
        check("R7 history cleared", int'(result), 7);
        convert(9'd6, "R7 after4", 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule